// File: doc/BRIEF.md
# LED Shift Chain Serializer

This block drives a string of external LEDs through a serial shift register followed by a parallel latch. It needs three pins: a slow LED clock, a serial data line and a latch strobe. Each refresh streams one bit per LED clock period in a fixed order: a user-defined header, then a formatted status group for each enabled port, then an optional 17-bit debug word, then a user-defined trailer. A latch period follows, and the next refresh begins at once.

The LED clock is divided down from the system clock by a programmable phase count. The header and trailer words sit in the block and can be loaded, bit-set or bit-cleared through a small write port. The per-port status groups come from outside already formatted, together with a common group length. An output polarity option supports LEDs that light on a low level.

Top module: `led_chain_ser`

## Requirements
- R1: Each level of `led_clk` lasts `phase`×`PHASE_UNIT` system clocks, with `phase` = 0 treated as 1. The first rising edge comes `phase`×`PHASE_UNIT` clocks after the first enabled clock edge.
- R2: The data bit changes only with a falling edge of `led_clk`, so every LED clock period carries exactly one slot.
- R3: A refresh carries the header, then the port groups from the lowest to the highest enabled port, then the debug word, then the trailer. Every field goes out least significant bit first.
- R4: The header takes `hdr_cnt` bits and the trailer takes `trl_cnt` bits. A count above 32 is taken as 32.
- R5: Each enabled port (`port_en[p]`=1) contributes bits 0 to `grp_len`-1 of `grp_data[6p+5:6p]`. A `grp_len` above 6 is taken as 6, and disabled ports send nothing.
- R6: When `dbg_en`=1, all 17 bits of `dbg_word` go out between the port groups and the trailer.
- R7: Empty segments, disabled ports and a disabled debug field produce no slots. If every segment is empty, every slot is a latch slot.
- R8: After the last bit, `led_lat` stays high for exactly one LED clock period while the data line is at its inactive level. The next refresh follows with no gap.
- R9: `led_dat` is the chain bit when `polarity`=0 and its inverse when `polarity`=1. The inactive data level equals `polarity`.
- R10: While `enable`=0, `led_clk` and `led_lat` are low and `led_dat` is at its inactive level. Enabling again restarts the chain at the header.
- R11: A write with `udd_wr`=1 targets the header word when `udd_sel`=0 and the trailer word when `udd_sel`=1. The operation `udd_op` works as follows: 0 loads `udd_wdata`, 1 sets the bits that are 1 in `udd_wdata`, 2 clears them, and 3 leaves the word unchanged. Both words reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the shift chain |
| polarity | input | 1 | 1 inverts the data output |
| phase | input | 7 | LED clock half-period in units of PHASE_UNIT clocks |
| hdr_cnt | input | 6 | Header bit count |
| trl_cnt | input | 6 | Trailer bit count |
| udd_wr | input | 1 | Write strobe for header/trailer words |
| udd_sel | input | 1 | 0 header, 1 trailer |
| udd_op | input | 2 | 0 load, 1 set, 2 clear, 3 no change |
| udd_wdata | input | 32 | Write data or bit mask |
| port_en | input | 8 | Per-port display enable |
| grp_len | input | 3 | Bits per port group |
| grp_data | input | 48 | Formatted groups, 6 bits per port |
| dbg_en | input | 1 | Adds the debug word to the chain |
| dbg_word | input | 17 | Debug data |
| led_clk | output | 1 | LED shift clock |
| led_dat | output | 1 | Serial LED data |
| led_lat | output | 1 | Latch strobe |

## Verification
The bench checks the segment boundaries. A sequencer that inserted an idle slot at an empty segment, or visited ports out of order, would shift every later LED by one position, and the bench detects this as a wrong frame length or a first wrong bit. The clamps for counts above 32 and group lengths above 6 are tested at their limits, where a design without the clamp would read past the data word or stretch the frame. The bench also disables the block in the middle of a frame and checks that the next frame starts at the header and that the latch slot lasts exactly one period.

// File: rtl/led_chain_pkg.sv
// Shared types for the LED shift chain serializer.
package led_chain_pkg;
    // Segment currently being shifted; LAT is the latch period.
    typedef enum logic [2:0] {
        SEG_HDR = 3'd0,
        SEG_PRT = 3'd1,
        SEG_DBG = 3'd2,
        SEG_TRL = 3'd3,
        SEG_LAT = 3'd4
    } seg_e;

    // Header/trailer word update operation.
    typedef enum logic [1:0] {
        UDD_LOAD  = 2'd0,
        UDD_SET   = 2'd1,
        UDD_CLEAR = 2'd2,
        UDD_HOLD  = 2'd3
    } udd_op_e;
endpackage

// File: rtl/led_phase_clk.sv
// LED clock divider. While run is high, each LED clock level lasts
// max(phase,1)*PHASE_UNIT system clocks. first_slot marks the first enabled
// cycle, and slot_tick marks every cycle whose edge opens a new slot
// (falling LED clock or first start). Assumes phase changes are rare; a
// smaller phase mid-count ends the current level at the next cycle.
module led_phase_clk #(
    parameter int PHASE_W    = 7,
    parameter int PHASE_UNIT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PHASE_W-1:0] phase,
    output logic               led_clk,
    output logic               slot_tick,
    output logic               first_slot
);
    localparam int CNT_W = PHASE_W + $clog2(PHASE_UNIT) + 1;

    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   lim;
    logic [PHASE_W-1:0] ph_eff;
    logic               clk_q;
    logic               started_q;
    logic               wrap;

    // Half-period limit with phase 0 read as 1.
    always_comb begin
        ph_eff = (phase == '0) ? PHASE_W'(1) : phase;
        lim    = CNT_W'(ph_eff) * CNT_W'(PHASE_UNIT);
        wrap   = (cnt_q >= (lim - CNT_W'(1)));
    end

    assign first_slot = run && !started_q;
    assign slot_tick  = first_slot || (run && started_q && wrap && clk_q);
    assign led_clk    = clk_q;

    // Half-period counter and LED clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q     <= '0;
            clk_q     <= 1'b0;
            started_q <= 1'b0;
        end else begin
            started_q <= 1'b1;
            if (!started_q) begin
                cnt_q <= '0;
            end else if (wrap) begin
                cnt_q <= '0;
                clk_q <= ~clk_q;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/led_udd_bank.sv
// Header (index 0) and trailer (index 1) user data words with load, bitwise
// set and bitwise clear writes. Assumes one write per cycle.
module led_udd_bank
    import led_chain_pkg::*;
#(
    parameter int UDD_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [1:0]       op,
    input  logic [UDD_W-1:0] wdata,
    output logic [UDD_W-1:0] hdr_word,
    output logic [UDD_W-1:0] trl_word
);
    localparam int NWORDS = 2;

    logic [UDD_W-1:0] word_q [NWORDS];
    udd_op_e          op_e;

    assign op_e = udd_op_e'(op);

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        // Apply the selected update to this word when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (wr && (int'(sel) == g)) begin
                case (op_e)
                    UDD_LOAD:  word_q[g] <= wdata;
                    UDD_SET:   word_q[g] <= word_q[g] | wdata;
                    UDD_CLEAR: word_q[g] <= word_q[g] & ~wdata;
                    default:   word_q[g] <= word_q[g];
                endcase
            end
        end
    end

    assign hdr_word = word_q[0];
    assign trl_word = word_q[1];
endmodule

// File: rtl/led_chain_seq.sv
// Chain sequencer. It keeps a pointer to the next slot (segment, bit index,
// port), loads that slot's bit and latch flag on each slot_tick, and steps
// the pointer past empty segments and disabled ports in the same cycle.
// Assumes UDD_W >= DBG_W and UDD_W >= GW. A pointer left out of range by a
// configuration change moves on at the next slot.
module led_chain_seq
    import led_chain_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int GW        = 6,
    parameter int UDD_W     = 32,
    parameter int DBG_W     = 17,
    localparam int CW       = $clog2(UDD_W + 1),
    localparam int GLW      = $clog2(GW + 1),
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    slot_tick,
    input  logic                    first_slot,
    input  logic [UDD_W-1:0]        hdr_word,
    input  logic [UDD_W-1:0]        trl_word,
    input  logic [CW-1:0]           hdr_cnt,
    input  logic [CW-1:0]           trl_cnt,
    input  logic [NUM_PORTS-1:0]    port_en,
    input  logic [GLW-1:0]          grp_len,
    input  logic [NUM_PORTS*GW-1:0] grp_data,
    input  logic                    dbg_en,
    input  logic [DBG_W-1:0]        dbg_word,
    output logic                    bit_out,
    output logic                    lat_out
);
    localparam int UIW = $clog2(UDD_W);
    localparam int DIW = $clog2(DBG_W);
    localparam int GIW = (GW > 1) ? $clog2(GW) : 1;

    logic [GW-1:0]     grp [NUM_PORTS];
    logic [CW-1:0]     hc, tc;
    logic [GLW-1:0]    gl;
    seg_e              seg_q, cur_seg, nxt_seg;
    seg_e              hdr_entry, prt_entry, dbg_entry, trl_entry;
    logic [CW-1:0]     idx_q, cur_idx, nxt_idx;
    logic [PORT_W-1:0] port_q, cur_port, nxt_port;
    logic [PORT_W-1:0] first_p, later_p;
    logic              any_en, later_ok;
    logic              cur_bit;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_grp
        assign grp[g] = grp_data[g*GW +: GW];
    end

    // Clamp the programmed lengths to their field widths.
    always_comb begin
        hc = (hdr_cnt > CW'(UDD_W)) ? CW'(UDD_W) : hdr_cnt;
        tc = (trl_cnt > CW'(UDD_W)) ? CW'(UDD_W) : trl_cnt;
        gl = (grp_len > GLW'(GW)) ? GLW'(GW) : grp_len;
    end

    // Lowest enabled port overall.
    always_comb begin
        any_en  = 1'b0;
        first_p = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (port_en[i]) begin
                any_en  = 1'b1;
                first_p = PORT_W'(i);
            end
        end
    end

    // Segment that a refresh, or a finished segment, falls through to.
    always_comb begin
        trl_entry = (tc != '0) ? SEG_TRL : SEG_LAT;
        dbg_entry = dbg_en ? SEG_DBG : trl_entry;
        prt_entry = ((gl != '0) && any_en) ? SEG_PRT : dbg_entry;
        hdr_entry = (hc != '0) ? SEG_HDR : prt_entry;
    end

    // Slot emitted at this tick: the refresh start, or the stored pointer.
    always_comb begin
        cur_seg  = first_slot ? hdr_entry : seg_q;
        cur_idx  = first_slot ? '0 : idx_q;
        cur_port = first_slot ? first_p : port_q;
    end

    // Lowest enabled port above the current one.
    always_comb begin
        later_ok = 1'b0;
        later_p  = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (port_en[i] && (i > int'(cur_port))) begin
                later_ok = 1'b1;
                later_p  = PORT_W'(i);
            end
        end
    end

    // Pointer step, skipping empty segments in the same cycle.
    always_comb begin
        nxt_seg  = cur_seg;
        nxt_idx  = cur_idx + CW'(1);
        nxt_port = cur_port;
        case (cur_seg)
            SEG_HDR: if (int'(cur_idx) + 1 >= int'(hc)) begin
                nxt_seg  = prt_entry;
                nxt_idx  = '0;
                nxt_port = first_p;
            end
            SEG_PRT: if (int'(cur_idx) + 1 >= int'(gl)) begin
                nxt_idx = '0;
                if (later_ok) nxt_port = later_p;
                else          nxt_seg  = dbg_entry;
            end
            SEG_DBG: if (int'(cur_idx) + 1 >= DBG_W) begin
                nxt_seg = trl_entry;
                nxt_idx = '0;
            end
            SEG_TRL: if (int'(cur_idx) + 1 >= int'(tc)) begin
                nxt_seg = SEG_LAT;
                nxt_idx = '0;
            end
            default: begin
                nxt_seg  = hdr_entry;
                nxt_idx  = '0;
                nxt_port = first_p;
            end
        endcase
    end

    // Bit carried by the current slot.
    always_comb begin
        case (cur_seg)
            SEG_HDR: cur_bit = hdr_word[cur_idx[UIW-1:0]];
            SEG_PRT: cur_bit = grp[cur_port][cur_idx[GIW-1:0]];
            SEG_DBG: cur_bit = dbg_word[cur_idx[DIW-1:0]];
            SEG_TRL: cur_bit = trl_word[cur_idx[UIW-1:0]];
            default: cur_bit = 1'b0;
        endcase
    end

    // Pointer and slot output registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            seg_q   <= SEG_HDR;
            idx_q   <= '0;
            port_q  <= '0;
            bit_out <= 1'b0;
            lat_out <= 1'b0;
        end else if (slot_tick) begin
            seg_q   <= nxt_seg;
            idx_q   <= nxt_idx;
            port_q  <= nxt_port;
            bit_out <= cur_bit;
            lat_out <= (cur_seg == SEG_LAT);
        end
    end
endmodule

// File: rtl/led_chain_ser.sv
// LED shift chain serializer top. It joins the clock divider, the
// header/trailer word bank and the sequencer, and applies output polarity.
// Assumes the port groups arrive already formatted and held stable for at
// least one refresh.
module led_chain_ser #(
    parameter int NUM_PORTS  = 8,
    parameter int GW         = 6,
    parameter int UDD_W      = 32,
    parameter int DBG_W      = 17,
    parameter int PHASE_W    = 7,
    parameter int PHASE_UNIT = 64,
    localparam int CW        = $clog2(UDD_W + 1),
    localparam int GLW       = $clog2(GW + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    polarity,
    input  logic [PHASE_W-1:0]      phase,
    input  logic [CW-1:0]           hdr_cnt,
    input  logic [CW-1:0]           trl_cnt,
    input  logic                    udd_wr,
    input  logic                    udd_sel,
    input  logic [1:0]              udd_op,
    input  logic [UDD_W-1:0]        udd_wdata,
    input  logic [NUM_PORTS-1:0]    port_en,
    input  logic [GLW-1:0]          grp_len,
    input  logic [NUM_PORTS*GW-1:0] grp_data,
    input  logic                    dbg_en,
    input  logic [DBG_W-1:0]        dbg_word,
    output logic                    led_clk,
    output logic                    led_dat,
    output logic                    led_lat
);
    logic             slot_tick;
    logic             first_slot;
    logic             chain_bit;
    logic [UDD_W-1:0] hdr_word;
    logic [UDD_W-1:0] trl_word;

    led_phase_clk #(
        .PHASE_W   (PHASE_W),
        .PHASE_UNIT(PHASE_UNIT)
    ) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .phase     (phase),
        .led_clk   (led_clk),
        .slot_tick (slot_tick),
        .first_slot(first_slot)
    );

    led_udd_bank #(
        .UDD_W(UDD_W)
    ) u_udd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (udd_wr),
        .sel     (udd_sel),
        .op      (udd_op),
        .wdata   (udd_wdata),
        .hdr_word(hdr_word),
        .trl_word(trl_word)
    );

    led_chain_seq #(
        .NUM_PORTS(NUM_PORTS),
        .GW       (GW),
        .UDD_W    (UDD_W),
        .DBG_W    (DBG_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .slot_tick (slot_tick),
        .first_slot(first_slot),
        .hdr_word  (hdr_word),
        .trl_word  (trl_word),
        .hdr_cnt   (hdr_cnt),
        .trl_cnt   (trl_cnt),
        .port_en   (port_en),
        .grp_len   (grp_len),
        .grp_data  (grp_data),
        .dbg_en    (dbg_en),
        .dbg_word  (dbg_word),
        .bit_out   (chain_bit),
        .lat_out   (led_lat)
    );

    // Polarity applied after the register; a zero chain bit reads as dark.
    assign led_dat = chain_bit ^ polarity;
endmodule

// File: rtl/led_chain_ser_chk.sv
// Protocol checker for the LED pins, bound into led_chain_ser.
module led_chain_ser_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic polarity,
    input logic led_clk,
    input logic led_dat,
    input logic led_lat
);
    // R10: disabled outputs go idle by the next cycle.
    p_idle_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!led_clk && !led_lat));

    // R10: the data line rests at its inactive level while disabled.
    p_idle_dat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |-> (led_dat == polarity));

    // R8: data is dark during the latch slot.
    p_lat_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (led_lat && enable && $past(enable)) |-> (led_dat == polarity));

    // R2: data moves only with a falling LED clock while running.
    p_dat_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && $past(enable, 2) && $stable(polarity)
         && !$stable(led_dat)) |-> $fell(led_clk));

    // R8: the latch strobe also moves only with a falling LED clock.
    p_lat_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && $past(enable, 2) && !$stable(led_lat))
        |-> $fell(led_clk));
endmodule

bind led_chain_ser led_chain_ser_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .polarity(polarity),
    .led_clk (led_clk),
    .led_dat (led_dat),
    .led_lat (led_lat)
);

// File: tb/led_chain_ser_tb_top.sv
module led_chain_ser_tb_top;
    localparam int UNIT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        polarity = 1'b0;
    logic [6:0]  phase = 7'd1;
    logic [5:0]  hdr_cnt = '0;
    logic [5:0]  trl_cnt = '0;
    logic        udd_wr = 1'b0;
    logic        udd_sel = 1'b0;
    logic [1:0]  udd_op = '0;
    logic [31:0] udd_wdata = '0;
    logic [7:0]  port_en = '0;
    logic [2:0]  grp_len = '0;
    logic [47:0] grp_data = 48'h9E37_A5C1_D42B;
    logic        dbg_en = 1'b0;
    logic [16:0] dbg_word = 17'h1_5A3C;
    logic        led_clk, led_dat, led_lat;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] hdr_m = '0;
    logic [31:0] trl_m = '0;
    bit   exp_b [0:299];
    bit   got_b [0:299];
    int   exp_n, got_n;

    always #4 clk = ~clk;

    led_chain_ser #(.PHASE_UNIT(UNIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .polarity(polarity),
        .phase(phase), .hdr_cnt(hdr_cnt), .trl_cnt(trl_cnt),
        .udd_wr(udd_wr), .udd_sel(udd_sel), .udd_op(udd_op),
        .udd_wdata(udd_wdata), .port_en(port_en), .grp_len(grp_len),
        .grp_data(grp_data), .dbg_en(dbg_en), .dbg_word(dbg_word),
        .led_clk(led_clk), .led_dat(led_dat), .led_lat(led_lat)
    );

    task automatic check_int(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Expected chain from the requirements (R3..R7).
    task automatic build_exp();
        int hc, tc, gl;
        hc = (hdr_cnt > 32) ? 32 : int'(hdr_cnt);
        tc = (trl_cnt > 32) ? 32 : int'(trl_cnt);
        gl = (grp_len > 6) ? 6 : int'(grp_len);
        exp_n = 0;
        for (int i = 0; i < hc; i++) begin exp_b[exp_n] = hdr_m[i]; exp_n++; end
        for (int p = 0; p < 8; p++)
            if (port_en[p])
                for (int i = 0; i < gl; i++) begin
                    exp_b[exp_n] = grp_data[p*6+i]; exp_n++;
                end
        if (dbg_en)
            for (int i = 0; i < 17; i++) begin exp_b[exp_n] = dbg_word[i]; exp_n++; end
        for (int i = 0; i < tc; i++) begin exp_b[exp_n] = trl_m[i]; exp_n++; end
    endtask

    // Collect slots on rising LED clock until a latch slot (R8 dark check).
    task automatic capture_frame();
        got_n = 0;
        for (int k = 0; k < 300; k++) begin
            @(posedge led_clk); #1;
            if (led_lat) begin
                check_int("R8", "latch slot data level", int'(led_dat), int'(polarity));
                return;
            end
            got_b[got_n] = led_dat ^ polarity;
            got_n++;
        end
    endtask

    task automatic check_frame(string req, string what);
        int bad;
        build_exp();
        capture_frame();
        check_int(req, {what, " length"}, got_n, exp_n);
        bad = -1;
        for (int i = 0; i < got_n && i < exp_n; i++)
            if (got_b[i] != exp_b[i] && bad < 0) bad = i;
        check_int(req, {what, " first wrong bit"}, bad, -1);
    endtask

    task automatic stop_chain();
        @(negedge clk) enable = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic start_chain();
        @(negedge clk) enable = 1'b1;
    endtask

    task automatic udd_write(bit sel, logic [1:0] op, logic [31:0] d);
        @(negedge clk);
        udd_wr = 1'b1; udd_sel = sel; udd_op = op; udd_wdata = d;
        @(negedge clk);
        udd_wr = 1'b0;
        case (op)
            2'd0: if (sel) trl_m = d;          else hdr_m = d;
            2'd1: if (sel) trl_m = trl_m | d;  else hdr_m = hdr_m | d;
            2'd2: if (sel) trl_m = trl_m & ~d; else hdr_m = hdr_m & ~d;
            default: ;
        endcase
    endtask

    // Reset and idle levels (R10, R9).
    task automatic t_reset();
        repeat (4) @(negedge clk);
        check_int("R10", "reset led_clk", int'(led_clk), 0);
        check_int("R10", "reset led_lat", int'(led_lat), 0);
        check_int("R10", "reset led_dat", int'(led_dat), 0);
        polarity = 1'b1; #1;
        check_int("R9", "idle data with polarity 1", int'(led_dat), 1);
        polarity = 1'b0;
    endtask

    // LED clock timing (R1).
    task automatic t_clock(int ph);
        int c, l;
        l = ((ph == 0) ? 1 : ph) * UNIT;
        stop_chain();
        phase = 7'(ph);
        start_chain();
        c = 0;
        do begin @(posedge clk); #1; c++; end while (!led_clk);
        check_int("R1", $sformatf("phase %0d first rise", ph), c, l + 1);
        c = 0;
        do begin @(posedge clk); #1; c++; end while (led_clk);
        check_int("R1", $sformatf("phase %0d high level", ph), c, l);
        c = 0;
        do begin @(posedge clk); #1; c++; end while (!led_clk);
        check_int("R1", $sformatf("phase %0d low level", ph), c, l);
        stop_chain();
        phase = 7'd1;
    endtask

    // Header/trailer word writes seen through the chain (R11, R3).
    task automatic t_udd();
        udd_write(1'b0, 2'd0, 32'hA5A5_0F0F);
        udd_write(1'b0, 2'd1, 32'h0000_F000);
        udd_write(1'b0, 2'd2, 32'h0000_000F);
        udd_write(1'b0, 2'd3, 32'hFFFF_FFFF);
        udd_write(1'b1, 2'd0, 32'h1234_5678);
        udd_write(1'b1, 2'd2, 32'h0000_00FF);
        hdr_cnt = 6'd32; trl_cnt = 6'd32; port_en = '0; dbg_en = 1'b0;
        start_chain();
        check_frame("R11", "load/set/clear/hold words");
        stop_chain();
    endtask

    // Mixed frame then an immediate repeat (R3, R5, R6, R8).
    task automatic t_mixed(string req);
        udd_write(1'b0, 2'd0, 32'h0000_0016);
        udd_write(1'b1, 2'd0, 32'h0000_0009);
        hdr_cnt = 6'd5; trl_cnt = 6'd4; port_en = 8'b1000_0101;
        grp_len = 3'd3; dbg_en = 1'b1;
        start_chain();
        check_frame(req, "mixed frame first");
        check_frame("R8", "mixed frame repeat");
        stop_chain();
    endtask

    // Empty segments skipped; all-empty chain is all latch slots (R7).
    task automatic t_skip();
        hdr_cnt = '0; trl_cnt = 6'd3; port_en = 8'b0001_0000;
        grp_len = 3'd4; dbg_en = 1'b0;
        start_chain();
        check_frame("R7", "sparse frame");
        stop_chain();
        trl_cnt = '0; port_en = '0;
        start_chain();
        check_frame("R7", "empty frame 1");
        check_frame("R7", "empty frame 2");
        stop_chain();
    endtask

    // Over-range counts clamp to full size, 129 bits (R4, R5).
    task automatic t_clamp();
        udd_write(1'b0, 2'd0, 32'hC0DE_5EED);
        udd_write(1'b1, 2'd0, 32'h8BAD_F00D);
        hdr_cnt = 6'd50; trl_cnt = 6'd63; port_en = 8'hFF;
        grp_len = 3'd7; dbg_en = 1'b1;
        start_chain();
        check_frame("R4", "clamped full frame");
        stop_chain();
        grp_len = 3'd6; hdr_cnt = 6'd33; trl_cnt = '0; dbg_en = 1'b0;
        start_chain();
        check_frame("R5", "group length 6, header 33");
        stop_chain();
    endtask

    // Abort mid-frame, then restart from header (R10).
    task automatic t_abort();
        hdr_cnt = 6'd8; trl_cnt = 6'd8; port_en = 8'b0100_0010;
        grp_len = 3'd2; dbg_en = 1'b1;
        start_chain();
        repeat (7) @(posedge led_clk);
        @(negedge clk) enable = 1'b0;
        @(negedge clk); @(negedge clk);
        check_int("R10", "aborted led_clk", int'(led_clk), 0);
        check_int("R10", "aborted led_lat", int'(led_lat), 0);
        check_int("R10", "aborted led_dat", int'(led_dat), int'(polarity));
        start_chain();
        check_frame("R10", "restart frame");
        stop_chain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clock(3);
        t_clock(0);
        t_udd();
        t_mixed("R3");
        polarity = 1'b1;
        t_mixed("R9");
        polarity = 1'b0;
        t_mixed("R6");
        t_skip();
        t_clamp();
        t_abort();
        summary();
    end
endmodule